// File: doc/BRIEF.md
# Rotate, Shift and Mask Unit

A purely combinational 64-bit datapath for an integer execution stage. One rotator and one mask generator serve every rotate-and-mask form, both insert forms, logical shifts in either direction and sign-propagating right shifts, in word (32-bit) and doubleword (64-bit) widths. Four mode flags steer the shared hardware. The mask limits come either from the shift amount or from fields in the instruction word, which arrives unchanged.

The unit computes the result and a carry flag in the same cycle the operands are presented. Operand selection, flag decode and condition-register updates belong to the surrounding pipeline.

Bit positions below count from the least significant bit (LSB = 0). A mask *position* p counts from the most significant bit (p = 63 - LSB index). A mask from begin b to end e covers positions b..e when b <= e. When b > e it covers positions >= b together with positions <= e.

Top module: `rsm_unit`

## Requirements
- R1: With `wordMode`, `clearLeft` and `clearRight` all high, the low word of `srcVal` is copied into both halves and rotated left by `shAmt[4:0]`. It is then kept over the mask from position 32+`instrWord[10:6]` to position 32+`instrWord[5:1]`, and every bit outside that mask comes from `insVal`.
- R2: When the mask begin position exceeds the mask end position, the mask wraps: it covers the positions from begin to 63 and from 0 to end.
- R3: In doubleword mode with only `clearLeft` high, `srcVal` is rotated left by `shAmt[5:0]` and positions before the 6-bit field {`instrWord[5]`,`instrWord[10:6]`} are cleared; `insVal` has no effect.
- R4: In doubleword mode with only `clearRight` high, `srcVal` is rotated left by `shAmt[5:0]` and positions after the 6-bit field {`instrWord[5]`,`instrWord[10:6]`} are cleared.
- R5: In doubleword mode with both clear flags high, the rotation is by `shAmt[5:0]` and the mask runs from the 6-bit field to position 63-`shAmt[5:0]`, with `insVal` supplying the bits outside it.
- R6: With both clear flags low and `shiftRight` low, the unit shifts left logically, by `shAmt[5:0]` in doubleword mode or by `shAmt[4:0]` on the low word in word mode, where the upper 32 result bits are zero.
- R7: With both clear flags low, `shiftRight` high and `arithMode` low, the unit shifts right logically; word shifts act on the low word with a zero upper half, and ignore `shAmt[6]`.
- R8: A logical shift with `shAmt[5]` set (word) or `shAmt[6]` set (doubleword) yields zero.
- R9: With `arithMode` and `shiftRight` high and both clear flags low, vacated bits take the sign (bit 31 in word mode, bit 63 otherwise), word results are sign-extended into the upper half, and an out-of-range amount (as in R8) gives all sign bits.
- R10: For arithmetic right shifts `carryOut` is 1 exactly when the sign bit is 1 and at least one 1 bit of the operand (low word in word mode) is shifted out.
- R11: `carryOut` is 0 for every operation other than an arithmetic right shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcVal | input | 64 | Operand that is rotated or shifted |
| insVal | input | 64 | Operand supplying bits outside the mask for insert forms |
| shAmt | input | 7 | Rotate or shift amount |
| instrWord | input | 32 | Instruction word carrying the mask limit fields |
| wordMode | input | 1 | 1 selects 32-bit operation |
| shiftRight | input | 1 | 1 selects right shift when both clear flags are low |
| arithMode | input | 1 | 1 selects sign-propagating right shift |
| clearLeft | input | 1 | Mask begin comes from the instruction word |
| clearRight | input | 1 | Mask end comes from the instruction word (or the amount) |
| result | output | 64 | Rotated, shifted or masked value |
| carryOut | output | 1 | Carry from arithmetic right shifts |

## Verification
An arithmetic right shift fills the vacated bits with sign and decides the carry in the same evaluation. Both outputs come from the same rotated value and the same mask. They can disagree when the mask or the dropped-bit window is wrong. The bench applies negative and positive sources, with and without 1 bits in the dropped positions, including amounts past the operand width. It compares the result and the carry together against an independent shift model in the same sample.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  localparam int RSM_DATA_W = 64;
  localparam int RSM_LG     = $clog2(RSM_DATA_W);

  // Strobes from control to datapath
  typedef struct packed {
    logic [RSM_LG-1:0] rotAmt;
    logic [RSM_LG-1:0] maskBegin;
    logic [RSM_LG-1:0] maskEnd;
    logic              forceZeroMask;
    logic              mergeIns;
    logic              signFill;
    logic              wordMode;
  } rsm_strobe_t;
endpackage

// File: rtl/rsm_ctrl.sv
module rsm_ctrl
  import rsm_pkg::*;
#(
  parameter int DATA_W = RSM_DATA_W
) (
  input  logic [$clog2(DATA_W):0] shAmt,
  input  logic [31:0]             instrWord,
  input  logic                    wordMode,
  input  logic                    shiftRight,
  input  logic                    arithMode,
  input  logic                    clearLeft,
  input  logic                    clearRight,
  output rsm_strobe_t             strobe
);
  localparam int LG = $clog2(DATA_W);
  localparam logic [LG-1:0] ALL_ONES = {LG{1'b1}};
  localparam logic [LG-1:0] HALF_BASE = {1'b1, {(LG-1){1'b0}}};

  logic          plainShift;
  logic [LG-1:0] amt;
  logic [LG-1:0] fieldWide;
  logic [LG-1:0] wordBegin;
  logic [LG-1:0] wordEnd;
  logic          unusedIw;

  assign unusedIw   = ^{instrWord[31:11], instrWord[0]};
  assign plainShift = !clearLeft && !clearRight;
  assign amt        = wordMode ? {1'b0, shAmt[LG-2:0]} : shAmt[LG-1:0];
  assign fieldWide  = {instrWord[5], instrWord[10:6]};
  assign wordBegin  = {1'b1, instrWord[10:6]};
  assign wordEnd    = {1'b1, instrWord[5:1]};

  always_comb begin
    strobe = '0;
    strobe.wordMode      = wordMode;
    strobe.mergeIns      = clearLeft && clearRight;
    strobe.signFill      = plainShift && shiftRight && arithMode;
    strobe.forceZeroMask = plainShift && (wordMode ? shAmt[LG-1] : shAmt[LG]);
    strobe.rotAmt        = (plainShift && shiftRight) ? (LG'(0) - amt) : amt;

    if (clearLeft)
      strobe.maskBegin = wordMode ? wordBegin : fieldWide;
    else if (plainShift && shiftRight)
      strobe.maskBegin = wordMode ? (HALF_BASE | amt) : amt;
    else
      strobe.maskBegin = wordMode ? HALF_BASE : '0;

    if (clearRight) begin
      if (wordMode)
        strobe.maskEnd = wordEnd;
      else
        strobe.maskEnd = clearLeft ? (ALL_ONES - amt) : fieldWide;
    end else if (clearLeft || shiftRight)
      strobe.maskEnd = ALL_ONES;
    else
      strobe.maskEnd = ALL_ONES - amt;
  end
endmodule

// File: rtl/rsm_rotator.sv
module rsm_rotator #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]         dataIn,
  input  logic [$clog2(DATA_W)-1:0] amt,
  output logic [DATA_W-1:0]         dataOut
);
  localparam int LG = $clog2(DATA_W);

  logic [DATA_W-1:0] stage [0:LG];

  assign stage[0] = dataIn;

  for (genvar s = 0; s < LG; s++) begin : g_stage
    localparam int K = 1 << s;
    assign stage[s+1] = amt[s]
      ? {stage[s][DATA_W-1-K:0], stage[s][DATA_W-1:DATA_W-K]}
      : stage[s];
  end

  assign dataOut = stage[LG];
endmodule

// File: rtl/rsm_mask.sv
module rsm_mask #(
  parameter int DATA_W = 64
) (
  input  logic [$clog2(DATA_W)-1:0] maskBegin,
  input  logic [$clog2(DATA_W)-1:0] maskEnd,
  output logic [DATA_W-1:0]         maskOut
);
  localparam int LG = $clog2(DATA_W);

  logic              wrap;
  logic [DATA_W-1:0] pastBegin;
  logic [DATA_W-1:0] beforeEnd;

  assign wrap = maskBegin > maskEnd;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    // position counted from the most significant bit
    localparam logic [LG-1:0] POS = LG'(DATA_W - 1 - i);
    assign pastBegin[i] = POS >= maskBegin;
    assign beforeEnd[i] = POS <= maskEnd;
  end

  assign maskOut = wrap ? (pastBegin | beforeEnd) : (pastBegin & beforeEnd);
endmodule

// File: rtl/rsm_datapath.sv
module rsm_datapath
  import rsm_pkg::*;
#(
  parameter int DATA_W = RSM_DATA_W
) (
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] insVal,
  input  rsm_strobe_t       strobe,
  output logic [DATA_W-1:0] result,
  output logic              carryOut
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] rotIn;
  logic [DATA_W-1:0] rotated;
  logic [DATA_W-1:0] rawMask;
  logic [DATA_W-1:0] keepMask;
  logic [DATA_W-1:0] fillVal;
  logic [DATA_W-1:0] dropWin;
  logic              signBit;

  assign rotIn = strobe.wordMode ? {2{srcVal[HALF-1:0]}} : srcVal;

  rsm_rotator #(.DATA_W(DATA_W)) u_rot (
    .dataIn (rotIn),
    .amt    (strobe.rotAmt),
    .dataOut(rotated)
  );

  rsm_mask #(.DATA_W(DATA_W)) u_mask (
    .maskBegin(strobe.maskBegin),
    .maskEnd  (strobe.maskEnd),
    .maskOut  (rawMask)
  );

  assign keepMask = strobe.forceZeroMask ? '0 : rawMask;
  assign signBit  = strobe.wordMode ? srcVal[HALF-1] : srcVal[DATA_W-1];
  assign fillVal  = strobe.mergeIns ? insVal
                                    : {DATA_W{strobe.signFill & signBit}};
  assign result   = (rotated & keepMask) | (fillVal & ~keepMask);

  // bits that left the operand sit in the low half (word) or anywhere
  assign dropWin  = {{HALF{~strobe.wordMode}}, {HALF{1'b1}}};
  assign carryOut = strobe.signFill & signBit & (|(rotated & ~keepMask & dropWin));
endmodule

// File: rtl/rsm_unit.sv
module rsm_unit
  import rsm_pkg::*;
#(
  parameter int DATA_W = RSM_DATA_W
) (
  input  logic [63:0] srcVal,
  input  logic [63:0] insVal,
  input  logic [6:0]  shAmt,
  input  logic [31:0] instrWord,
  input  logic        wordMode,
  input  logic        shiftRight,
  input  logic        arithMode,
  input  logic        clearLeft,
  input  logic        clearRight,
  output logic [63:0] result,
  output logic        carryOut
);
  rsm_strobe_t strobe;

  rsm_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .shAmt     (shAmt),
    .instrWord (instrWord),
    .wordMode  (wordMode),
    .shiftRight(shiftRight),
    .arithMode (arithMode),
    .clearLeft (clearLeft),
    .clearRight(clearRight),
    .strobe    (strobe)
  );

  rsm_datapath #(.DATA_W(DATA_W)) u_dp (
    .srcVal  (srcVal),
    .insVal  (insVal),
    .strobe  (strobe),
    .result  (result),
    .carryOut(carryOut)
  );
endmodule

// File: rtl/rsm_unit_chk.sv
module rsm_unit_chk (
  input logic [63:0] srcVal,
  input logic [6:0]  shAmt,
  input logic        wordMode,
  input logic        shiftRight,
  input logic        arithMode,
  input logic        clearLeft,
  input logic        clearRight,
  input logic [63:0] result,
  input logic        carryOut
);
  logic plain;
  logic overRange;
  logic sgn;

  assign plain     = !clearLeft && !clearRight;
  assign overRange = wordMode ? shAmt[5] : shAmt[6];
  assign sgn       = wordMode ? srcVal[31] : srcVal[63];

  always_comb begin
    if (!$isunknown({srcVal, shAmt, wordMode, shiftRight, arithMode,
                     clearLeft, clearRight, result, carryOut})) begin
      a_r11_carry_quiet: assert (!(carryOut && !(plain && shiftRight && arithMode)))
        else $error("carry raised outside arithmetic right shift");
      a_r10_carry_needs_sign: assert (!(carryOut && !sgn))
        else $error("carry raised for a non-negative source");
      a_r8_oversize_zero: assert (!(plain && !arithMode && overRange) || result == 64'd0)
        else $error("oversized logical shift not zero");
      a_r9_oversize_sign: assert (!(plain && shiftRight && arithMode && overRange)
                                  || result == {64{sgn}})
        else $error("oversized arithmetic shift not all sign");
      a_r6_word_left_upper: assert (!(plain && !shiftRight && wordMode) || result[63:32] == 32'd0)
        else $error("word left shift upper half not zero");
      a_r9_word_sign_ext: assert (!(plain && shiftRight && arithMode && wordMode)
                                  || result[63:32] == {32{result[31]}})
        else $error("word arithmetic shift not sign-extended");
    end
  end
endmodule

bind rsm_unit rsm_unit_chk u_chk (
  .srcVal    (srcVal),
  .shAmt     (shAmt),
  .wordMode  (wordMode),
  .shiftRight(shiftRight),
  .arithMode (arithMode),
  .clearLeft (clearLeft),
  .clearRight(clearRight),
  .result    (result),
  .carryOut  (carryOut)
);

// File: tb/rsm_unit_bench.sv
`timescale 1ns/1ps
module rsm_unit_bench;
  // flags order: {word, right, arith, clrLeft, clrRight}
  typedef struct packed {
    logic [63:0] src;
    logic [63:0] ins;
    logic [6:0]  sh;
    logic [31:0] iw;
    logic [4:0]  fl;
    logic [3:0]  req;
  } vec_t;

  function automatic logic [31:0] fld32(input logic [4:0] b, input logic [4:0] e);
    return {21'd0, b, e, 1'b0};
  endfunction

  function automatic logic [31:0] fld64(input logic [5:0] f);
    return {21'd0, f[4:0], f[5], 5'd0};
  endfunction

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{64'h0123_4567_89AB_CDEF, 64'h0,                 7'd8,  fld32(5'd4, 5'd27),  5'b10011, 4'd1},  // R1
    '{64'hDEAD_BEEF_1234_5678, 64'hAAAA_5555_AAAA_5555, 7'd13, fld32(5'd10, 5'd20), 5'b10011, 4'd1},  // R1 insert
    '{64'h0000_0000_F0F0_1234, 64'h0,                 7'd3,  fld32(5'd28, 5'd3),  5'b10011, 4'd2},  // R2
    '{64'hFEDC_BA98_7654_3210, 64'hFFFF_0000_FFFF_0000, 7'd20, fld64(6'd12),        5'b00010, 4'd3},  // R3
    '{64'hFEDC_BA98_7654_3210, 64'h0,                 7'd44, fld64(6'd40),        5'b00001, 4'd4},  // R4
    '{64'h0F1E_2D3C_4B5A_6978, 64'h0,                 7'd9,  fld64(6'd5),         5'b00011, 4'd5},  // R5
    '{64'h8877_6655_4433_2211, 64'h1111_2222_3333_4444, 7'd17, fld64(6'd50),        5'b00011, 4'd5},  // R5 insert
    '{64'hCAFE_F00D_0BAD_BEEF, 64'h5A5A_5A5A_5A5A_5A5A, 7'd40, fld64(6'd60),        5'b00011, 4'd2},  // R2 wide
    '{64'h9ABC_DEF0_1234_5678, 64'h0,                 7'd13, 32'd0,               5'b00000, 4'd6},  // R6
    '{64'hFFFF_FFFF_8765_4321, 64'h0,                 7'd7,  32'd0,               5'b10000, 4'd6},  // R6 word
    '{64'h9ABC_DEF0_1234_5678, 64'h0,                 7'd33, 32'd0,               5'b01000, 4'd7},  // R7
    '{64'hFFFF_FFFF_8765_4321, 64'h0,                 7'd9,  32'd0,               5'b11000, 4'd7},  // R7 word
    '{64'hFFFF_FFFF_8765_4321, 64'h0,                 7'd68, 32'd0,               5'b11000, 4'd7},  // R7 bit6 ignored
    '{64'h9ABC_DEF0_1234_5678, 64'h0,                 7'd69, 32'd0,               5'b00000, 4'd8},  // R8
    '{64'h1234_5678_FFFF_FFFF, 64'h0,                 7'd35, 32'd0,               5'b11000, 4'd8},  // R8 word
    '{64'h8000_0000_0000_0401, 64'h0,                 7'd10, 32'd0,               5'b01100, 4'd10}, // R10 carry
    '{64'h0000_0000_8000_0020, 64'h0,                 7'd5,  32'd0,               5'b11100, 4'd9},  // R9
    '{64'hFFFF_FFFF_7000_0007, 64'h0,                 7'd3,  32'd0,               5'b11100, 4'd10}, // R10 positive word
    '{64'h0000_0000_0000_0005, 64'h0,                 7'd70, 32'd0,               5'b01100, 4'd9}   // R9 oversize
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] srcVal = '0;
  logic [63:0] insVal = '0;
  logic [6:0]  shAmt = '0;
  logic [31:0] instrWord = '0;
  logic        wordMode = 1'b0;
  logic        shiftRight = 1'b0;
  logic        arithMode = 1'b0;
  logic        clearLeft = 1'b0;
  logic        clearRight = 1'b0;
  logic [63:0] result;
  logic        carryOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rsm_unit u_rsm_unit (
    .srcVal    (srcVal),
    .insVal    (insVal),
    .shAmt     (shAmt),
    .instrWord (instrWord),
    .wordMode  (wordMode),
    .shiftRight(shiftRight),
    .arithMode (arithMode),
    .clearLeft (clearLeft),
    .clearRight(clearRight),
    .result    (result),
    .carryOut  (carryOut)
  );

  // Independent reference built from the requirement text
  function automatic logic [64:0] refModel(input logic [63:0] src, input logic [63:0] ins,
                                           input logic [6:0] sh, input logic [31:0] iw,
                                           input logic [4:0] fl);
    logic        w32, rgt, ari, cl, cr;
    logic [31:0] w, rw;
    logic [63:0] r, rot, m, dropped;
    logic        c;
    int          n, mb, me;
    {w32, rgt, ari, cl, cr} = fl;
    c = 1'b0;
    if (!cl && !cr) begin
      if (w32) begin
        w = src[31:0];
        n = sh[5] ? 32 : int'(sh[4:0]);
        if (!rgt)     r = {32'd0, w << n};
        else if (!ari) r = {32'd0, w >> n};
        else begin
          rw = $signed(w) >>> n;
          r  = {{32{rw[31]}}, rw};
          dropped = {32'd0, w} & ((64'd1 << n) - 64'd1);
          c = w[31] && (dropped != 0);
        end
      end else begin
        n = sh[6] ? 64 : int'(sh[5:0]);
        if (!rgt)     r = src << n;
        else if (!ari) r = src >> n;
        else begin
          r = $signed(src) >>> n;
          dropped = src & ((64'd1 << n) - 64'd1);
          c = src[63] && (dropped != 0);
        end
      end
    end else begin
      if (w32) begin
        n  = int'(sh[4:0]);
        w  = src[31:0];
        rw = (w << n) | (w >> (32 - n));
        rot = {rw, rw};
        mb = 32 + int'(iw[10:6]);
        me = 32 + int'(iw[5:1]);
      end else begin
        n   = int'(sh[5:0]);
        rot = (src << n) | (src >> (64 - n));
        if (cl && cr) begin mb = int'({iw[5], iw[10:6]}); me = 63 - n; end
        else if (cl)  begin mb = int'({iw[5], iw[10:6]}); me = 63; end
        else          begin mb = 0; me = int'({iw[5], iw[10:6]}); end
      end
      for (int p = 0; p < 64; p++)
        m[63-p] = (mb <= me) ? (p >= mb && p <= me) : (p >= mb || p <= me);
      r = (rot & m) | ((cl && cr) ? (ins & ~m) : 64'd0);
    end
    return {c, r};
  endfunction

  task automatic apply(input logic [63:0] s, input logic [63:0] i, input logic [6:0] h,
                       input logic [31:0] iw, input logic [4:0] fl);
    @(posedge clk);
    srcVal = s; insVal = i; shAmt = h; instrWord = iw;
    {wordMode, shiftRight, arithMode, clearLeft, clearRight} = fl;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] gotR, input logic gotC,
                       input logic [63:0] expR, input logic expC);
    checks++;
    if (gotR !== expR || gotC !== expC) begin
      errors++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
               req, gotR, gotC, expR, expC);
    end
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: result=%h carry=%b expected completion", result, carryOut);
    finishRun();
  end

  initial begin
    logic [64:0] e;
    // idle state with all inputs low, under reset
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R6 idle", result, carryOut, 64'd0, 1'b0);
    rstN = 1'b1;

    // table walk
    for (int k = 0; k < NV; k++) begin
      apply(VECS[k].src, VECS[k].ins, VECS[k].sh, VECS[k].iw, VECS[k].fl);
      e = refModel(VECS[k].src, VECS[k].ins, VECS[k].sh, VECS[k].iw, VECS[k].fl);
      check($sformatf("R%0d row %0d", VECS[k].req, k), result, carryOut, e[63:0], e[64]);
    end

    // directed corner cases with hand-computed values
    apply(64'h1, 64'h0, 7'd4, 32'd0, 5'b00000);
    check("R6 dword left", result, carryOut, 64'h10, 1'b0);
    apply('1, 64'h0, 7'd64, 32'd0, 5'b01000);
    check("R8 dword right by 64", result, carryOut, 64'h0, 1'b0);
    apply(64'h8000_0000_0000_0000, 64'h0, 7'd64, 32'd0, 5'b01100);
    check("R9 dword arith by 64", result, carryOut, '1, 1'b1);
    apply(64'h0000_0000_8000_0010, 64'h0, 7'd4, 32'd0, 5'b11100);
    check("R10 word arith zeros dropped", result, carryOut, 64'hFFFF_FFFF_F800_0001, 1'b0);
    apply(64'h0000_0000_8000_0011, 64'h0, 7'd4, 32'd0, 5'b11100);
    check("R10 word arith one dropped", result, carryOut, 64'hFFFF_FFFF_F800_0001, 1'b1);
    apply('1, 64'h0, 7'd32, 32'd0, 5'b11000);
    check("R8 word right by 32", result, carryOut, 64'h0, 1'b0);
    apply(64'hFFFF_FFFF_0000_0001, 64'h0, 7'd31, 32'd0, 5'b10000);
    check("R6 word left upper cleared", result, carryOut, 64'h0000_0000_8000_0000, 1'b0);
    apply('1, 64'h0, 7'd0, fld32(5'd31, 5'd0), 5'b10011);
    check("R2 word wrap", result, carryOut, 64'hFFFF_FFFF_8000_0001, 1'b0);
    apply(64'h7, 64'h0, 7'd1, 32'd0, 5'b01100);
    check("R10 positive dword", result, carryOut, 64'h3, 1'b0);
    apply(64'h0000_0000_FFFF_FFFF, 64'h0, 7'd4, 32'd0, 5'b11000);
    check("R11 logical right negative word", result, carryOut, 64'h0FFF_FFFF, 1'b0);
    apply(64'h0, '1, 7'd5, fld64(6'd0), 5'b00010);
    check("R3 insert ignored", result, carryOut, 64'h0, 1'b0);
    apply(64'h0, '1, 7'd0, fld32(5'd0, 5'd31), 5'b10011);
    check("R1 insert outside word mask", result, carryOut, 64'hFFFF_FFFF_0000_0000, 1'b0);
    apply('1, 64'h0, 7'd0, fld64(6'd3), 5'b00001);
    check("R4 clear right of field", result, carryOut, 64'hF000_0000_0000_0000, 1'b0);
    apply('1, 64'h0, 7'd4, fld64(6'd8), 5'b00011);
    check("R5 begin to 63-amount", result, carryOut, 64'h00FF_FFFF_FFFF_FFF0, 1'b0);

    finishRun();
  end
endmodule